// File: doc/BRIEF.md
# Paged Memory Mapper with Mode Control

This block translates a 16-bit CPU address into a wider physical SRAM address. It keeps sixteen page registers. The top four CPU address bits choose one register. In mapped mode, the page number held in that register, with a bank number above it, takes the place of those four bits. The low twelve bits always pass through unchanged, so memory is divided into 4 KiB pages. In pass mode the physical address is simply the CPU address, zero-extended.

Two single-bit control inputs come from a bit-addressable I/O port outside the block. The first selects mapped or pass mode. The second opens a small register window at CPU addresses 0x4000 to 0x401F. While the window is open, ordinary CPU reads and writes there reach the page registers instead of normal memory.

A written word carries the page number in its high byte and the bank number in its low byte. Only the page and bank bits that the fitted memory needs are kept, so larger page numbers alias onto smaller ones. A register readback returns the page byte in both halves and never returns the bank.

Top module: `page_mapper_top`

## Requirements
- R1: After reset every page register holds page 0 and bank 0, so a readback of any register returns 0x0000.
- R2: With `map_en` low, `phys_addr` equals `cpu_addr` zero-extended to the physical width.
- R3: With `map_en` high, `phys_addr` is {bank, page, cpu_addr[11:0]} taken from the register selected by cpu_addr[15:12]. The original top nibble has no other effect; for example, register 0xA holding page 0x15 maps 0xA02E to 0x1502E.
- R4: phys_addr[11:0] equals cpu_addr[11:0] in both modes.
- R5: With `reg_en` high, an address in 0x4000..0x401F raises `reg_hit` and selects register cpu_addr[4:1]. Register n therefore sits at 0x4000 + 2n. A write with `cpu_wr` high updates that register on the clock edge of the write cycle.
- R6: With `reg_en` low, `reg_hit` stays low and writes never change a page register, even at window addresses.
- R7: The page is taken from wdata[15:8], and only its low PAGE_W bits (5 by default) are kept. With the default, a written 0xFF00 reads back as 0x1F1F.
- R8: The bank is taken from the low BANK_W bits of wdata[7:0] and is used only for translation. A readback returns {page byte, page byte}, so a written 0x0A01 reads back as 0x0A0A.
- R9: Two registers loaded with the same page and bank translate the same offset to the same physical address.
- R10: Page registers change only on a window write. Their contents survive changes of `map_en` and `reg_en`.
- R11: `reg_rdata` is 0x0000 whenever `reg_hit` is low. An address outside 0x4000..0x401F, such as 0x4020, never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data (page in high byte, bank in low byte) |
| cpu_wr | input | 1 | CPU write strobe for the current cycle |
| map_en | input | 1 | Mode control: 1 selects mapped translation, 0 selects pass mode |
| reg_en | input | 1 | Opens the page register window |
| phys_addr | output | 12+PAGE_W+BANK_W | Translated SRAM address |
| reg_hit | output | 1 | The current access targets a page register |
| reg_rdata | output | 16 | Page register readback, mirrored page byte |

## Verification
The assertions run on every cycle and cover the following:
- the offset passing through unchanged;
- identity translation in pass mode;
- no window hit while the window is closed;
- the mirrored readback, and the readback page staying inside the fitted page range;
- registers holding their value whenever no window write occurs.

Only the bench scenarios can show the remaining behaviour:
- which register a given window address writes;
- the exact mapped address built from the page and bank;
- the aliasing of oversized page numbers;
- two registers that share a page resolving to the same location;
- contents surviving a round trip through pass mode and a closed window.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int OFS_W = 12;
  localparam int SEL_W = 4;
  localparam int NREG  = 16;
  localparam logic [15:0] WIN_BASE = 16'h4000;

  // page field of a written word, masked to the fitted page width
  function automatic logic [7:0] page_of_word(input logic [15:0] w, input int pw);
    logic [7:0] mask;
    mask = (pw >= 8) ? 8'hFF : 8'((9'd1 << pw) - 9'd1);
    return w[15:8] & mask;
  endfunction

  // bank field of a written word, masked to the fitted bank width
  function automatic logic [7:0] bank_of_word(input logic [15:0] w, input int bw);
    logic [7:0] mask;
    mask = (bw >= 8) ? 8'hFF : 8'((9'd1 << bw) - 9'd1);
    return w[7:0] & mask;
  endfunction

  // upper address bits (15:5) compared against the register window
  function automatic logic in_window(input logic [10:0] upper);
    return upper == WIN_BASE[15:5];
  endfunction

  // readback word: page byte repeated in both halves
  function automatic logic [15:0] mirror_word(input logic [7:0] pg);
    return {pg, pg};
  endfunction
endpackage

// File: rtl/pmm_window_decode.sv
module pmm_window_decode
  import pmm_pkg::*;
(
  input  logic [15:1] addr_hi,
  input  logic        reg_en,
  output logic        hit,
  output logic [SEL_W-1:0] idx
);
  logic in_win;
  assign in_win = in_window(addr_hi[15:5]);
  assign hit    = reg_en && in_win;
  assign idx    = addr_hi[4:1];
endmodule

// File: rtl/pmm_page_file.sv
module pmm_page_file
  import pmm_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [15:0]       wr_data,
  input  logic [SEL_W-1:0]  xl_idx,
  output logic [PAGE_W-1:0] rd_page,
  output logic [PAGE_W-1:0] xl_page,
  output logic [BANK_W-1:0] xl_bank
);
  logic [NREG-1:0][PAGE_W-1:0] page_q;
  logic [NREG-1:0][BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] new_page;
  logic [BANK_W-1:0] new_bank;

  assign new_page = PAGE_W'(page_of_word(wr_data, PAGE_W));
  assign new_bank = BANK_W'(bank_of_word(wr_data, BANK_W));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q[g] <= '0;
        bank_q[g] <= '0;
      end else if (sel_w) begin
        page_q[g] <= new_page;
        bank_q[g] <= new_bank;
      end
    end
  end

  assign rd_page = page_q[wr_idx];
  assign xl_page = page_q[xl_idx];
  assign xl_bank = bank_q[xl_idx];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(page_q) && $stable(bank_q))); // R10
endmodule

// File: rtl/pmm_xlate.sv
module pmm_xlate
  import pmm_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int BANK_W = 2,
  localparam int PHYS_W = OFS_W + PAGE_W + BANK_W
) (
  input  logic              map_en,
  input  logic [15:0]       cpu_addr,
  input  logic [PAGE_W-1:0] page,
  input  logic [BANK_W-1:0] bank,
  output logic [PHYS_W-1:0] phys
);
  logic [PHYS_W-1:0] mapped;
  logic [PHYS_W-1:0] passed;
  assign mapped = {bank, page, cpu_addr[OFS_W-1:0]};
  assign passed = PHYS_W'(cpu_addr);
  assign phys   = map_en ? mapped : passed;
endmodule

// File: rtl/page_mapper_top.sv
module page_mapper_top
  import pmm_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int BANK_W = 2,
  localparam int PHYS_W = OFS_W + PAGE_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_wr,
  input  logic              map_en,
  input  logic              reg_en,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              reg_hit,
  output logic [15:0]       reg_rdata
);
  logic [SEL_W-1:0]  win_idx;
  logic              win_write;
  logic [PAGE_W-1:0] rd_page;
  logic [PAGE_W-1:0] xl_page;
  logic [BANK_W-1:0] xl_bank;

  pmm_window_decode u_dec (
    .addr_hi (cpu_addr[15:1]),
    .reg_en  (reg_en),
    .hit     (reg_hit),
    .idx     (win_idx)
  );

  assign win_write = reg_hit && cpu_wr;

  pmm_page_file #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (win_write),
    .wr_idx  (win_idx),
    .wr_data (cpu_wdata),
    .xl_idx  (cpu_addr[15:12]),
    .rd_page (rd_page),
    .xl_page (xl_page),
    .xl_bank (xl_bank)
  );

  pmm_xlate #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_xl (
    .map_en   (map_en),
    .cpu_addr (cpu_addr),
    .page     (xl_page),
    .bank     (xl_bank),
    .phys     (phys_addr)
  );

  assign reg_rdata = reg_hit ? mirror_word(8'(rd_page)) : 16'h0000;

  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]); // R4
  AST_PASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> (phys_addr[15:0] == cpu_addr && (phys_addr >> 16) == '0)); // R2
  AST_CLOSED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> !reg_hit); // R6
  AST_MIRROR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:8] == reg_rdata[7:0]); // R8
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:8] >> PAGE_W) == 8'h00); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> reg_rdata == 16'h0000); // R11
endmodule

// File: tb/tb_page_mapper_top.sv
module tb_page_mapper_top;
  localparam int PW = 5;
  localparam int BW = 2;
  localparam int PHW = 12 + PW + BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_wr = 1'b0;
  logic map_en = 1'b0;
  logic reg_en = 1'b0;
  logic [PHW-1:0] phys_addr;
  logic reg_hit;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  page_mapper_top #(.PAGE_W(PW), .BANK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .map_en(map_en), .reg_en(reg_en),
    .phys_addr(phys_addr), .reg_hit(reg_hit), .reg_rdata(reg_rdata)
  );

  typedef struct {
    logic [PHW-1:0] phys;
    logic           hit;
    logic [15:0]    rdata;
    string          tag;
  } exp_t;

  exp_t sb[$];
  event sample_ev;

  int unsigned m_page [16];
  int unsigned m_bank [16];

  // monitor: pops one expected item per sampled cycle
  initial begin
    forever begin
      @(sample_ev);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (phys_addr !== e.phys) begin
          errors++;
          $display("FAIL %s phys_addr got %h exp %h", e.tag, phys_addr, e.phys);
        end
        checks++;
        if (reg_hit !== e.hit) begin
          errors++;
          $display("FAIL %s reg_hit got %b exp %b", e.tag, reg_hit, e.hit);
        end
        checks++;
        if (reg_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s reg_rdata got %h exp %h", e.tag, reg_rdata, e.rdata);
        end
      end
    end
  end

  // driver: applies one cycle, pushes the expectation, updates model after write
  task automatic step(input logic [15:0] a, input logic [15:0] d, input logic w,
                      input logic m, input logic r, input string tag);
    exp_t e;
    int unsigned sel, widx;
    logic hit;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; map_en = m; reg_en = r;
    sel  = a >> 12;
    hit  = r && (a >= 16'h4000) && (a <= 16'h401F);
    widx = (a >> 1) & 15;
    if (m)
      e.phys = PHW'((m_bank[sel] << (12 + PW)) | (m_page[sel] << 12) | (a & 16'h0FFF));
    else
      e.phys = PHW'(a);
    e.hit   = hit;
    e.rdata = hit ? 16'((m_page[widx] << 8) | m_page[widx]) : 16'h0000;
    e.tag   = tag;
    sb.push_back(e);
    #2 -> sample_ev;
    #1;
    if (w && hit) begin
      m_page[widx] = (d >> 8) & ((1 << PW) - 1);
      m_bank[widx] = d & ((1 << BW) - 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_page[i] = 0; m_bank[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset contents, window open
    for (int i = 0; i < 16; i++)
      step(16'(16'h4000 + 2 * i), 16'h0, 1'b0, 1'b0, 1'b1, "R1 reset readback");
    // R2: pass mode identity
    step(16'hA02E, 16'h0, 1'b0, 1'b0, 1'b0, "R2 pass");
    step(16'hFFFF, 16'h0, 1'b0, 1'b0, 1'b0, "R2 R4 pass top");

    // R6: closed window write ignored
    step(16'h4014, 16'h1500, 1'b1, 1'b0, 1'b0, "R6 closed write");
    step(16'h4014, 16'h0, 1'b0, 1'b0, 1'b1, "R6 readback after closed write");

    // R5: load registers A..F with identity pages, then reg A with 0x15
    for (int i = 10; i < 16; i++)
      step(16'(16'h4000 + 2 * i), 16'(i << 8), 1'b1, 1'b0, 1'b1, "R5 load");
    step(16'h4014, 16'h1500, 1'b1, 1'b0, 1'b1, "R5 write reg A");
    step(16'h4014, 16'h0, 1'b0, 1'b0, 1'b1, "R5 readback reg A");
    step(16'h4016, 16'h0, 1'b0, 1'b0, 1'b1, "R5 readback reg B");

    // R7: oversized page aliases
    step(16'h4004, 16'hFF00, 1'b1, 1'b0, 1'b1, "R7 write 0xFF00");
    step(16'h4004, 16'h0, 1'b0, 1'b0, 1'b1, "R7 readback 0x1F1F");
    // R8: bank not returned
    step(16'h4006, 16'h0A01, 1'b1, 1'b0, 1'b1, "R8 write 0x0A01");
    step(16'h4006, 16'h0, 1'b0, 1'b0, 1'b1, "R8 readback 0x0A0A");

    // R3: mapped translation
    step(16'hA02E, 16'h0, 1'b0, 1'b1, 1'b0, "R3 R4 0xA02E to 0x1502E");
    step(16'h3123, 16'h0, 1'b0, 1'b1, 1'b0, "R3 R8 bank in phys");
    step(16'h2ABC, 16'h0, 1'b0, 1'b1, 1'b0, "R3 R7 aliased page");
    step(16'hC777, 16'h0, 1'b0, 1'b1, 1'b0, "R3 reg C");
    step(16'h0FFF, 16'h0, 1'b0, 1'b1, 1'b0, "R3 reg 0 zero page");

    // R9: shared page aliasing
    step(16'h4016, 16'h1500, 1'b1, 1'b1, 1'b1, "R9 write reg B");
    step(16'hA123, 16'h0, 1'b0, 1'b1, 1'b0, "R9 via A");
    step(16'hB123, 16'h0, 1'b0, 1'b1, 1'b0, "R9 via B");

    // R10: persistence across mode and enable changes
    step(16'hA02E, 16'h0, 1'b0, 1'b0, 1'b0, "R10 R2 back to pass");
    step(16'h1000, 16'h0, 1'b0, 1'b0, 1'b0, "R10 idle");
    step(16'h4014, 16'h0, 1'b0, 1'b0, 1'b1, "R10 readback reg A");
    step(16'h4006, 16'h0, 1'b0, 1'b1, 1'b1, "R10 readback reg 3");
    step(16'hA02E, 16'h0, 1'b0, 1'b1, 1'b0, "R10 R3 remapped");

    // R11: outside window, and closed-window translation of 0x4014
    step(16'h4020, 16'h0700, 1'b1, 1'b0, 1'b1, "R11 0x4020 no hit");
    step(16'h3FFE, 16'h0700, 1'b1, 1'b0, 1'b1, "R11 0x3FFE no hit");
    step(16'h4014, 16'h0, 1'b0, 1'b1, 1'b0, "R6 R3 window closed maps reg 4");
    step(16'h4014, 16'h0, 1'b0, 1'b0, 1'b1, "R11 reg A unchanged");

    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule